// File: doc/BRIEF.md
# Station Address PROM Loader

The block fetches the station identity from a byte-wide PROM after reset and turns it into a 48-bit MAC address that downstream logic can rely on. It reads eight bytes, one in each cycle, from a sparse layout in which each byte sits at a 16-byte boundary. Each byte is stored with its bit order reversed, so the block flips every byte as it arrives. The first six flipped bytes form the address. All eight take part in an XOR checksum, and the address is accepted only if that checksum equals 0xFF. Logic that reads the result is never shown a failed address.

The PROM port has a fixed latency of one cycle and no handshake. The block holds `prom_rd` high and drives `prom_addr` during a cycle, and the PROM returns the byte in the next cycle. Neither side can apply back-pressure: a read that has been issued is always taken. `start` is a plain level input that is sampled at each clock edge. After an identification succeeds, the block locks and ignores `start` until the next reset. After a failure, `start` begins a fresh attempt.

Top module: `station_id_loader`

## Requirements
- R1: An accepted start issues exactly eight PROM reads in eight consecutive cycles, starting in the cycle after the start edge, at byte addresses 0, 16, 32, 48, 64, 80, 96 and 112 in that order.
- R2: Each returned byte is bit-reversed before use: stored bit i becomes bit 7-i.
- R3: The first six reversed bytes form `mac_addr`. The first byte read goes to bits 47:40 and the sixth goes to bits 7:0.
- R4: The seventh and eighth bytes enter only the checksum and never appear in `mac_addr`.
- R5: `id_valid` goes high only if the XOR of all eight reversed bytes equals 0xFF.
- R6: When the checksum fails, `mac_addr` is all zeros and `id_valid` stays low.
- R7: `done` is a one-cycle pulse, high during the cycle after the ninth clock edge that follows the start edge. `id_valid` and `mac_addr` change on that same edge.
- R8: After a passing identification, `start` has no effect until reset: no PROM read, no `done`, and `mac_addr` and `id_valid` hold.
- R9: While an attempt is in progress, including its final result cycle, `start` is ignored.
- R10: After a failed attempt, a new `start` begins a complete new attempt.
- R11: During and after reset, `prom_rd`, `done`, `id_valid` and `mac_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request an identification attempt |
| prom_rd | output | 1 | PROM read strobe, one byte per cycle |
| prom_addr | output | 7 | PROM byte address |
| prom_data | input | 8 | PROM byte, valid the cycle after the read |
| mac_addr | output | 48 | Accepted station address, zero unless valid |
| done | output | 1 | One-cycle pulse when an attempt ends |
| id_valid | output | 1 | Checksum passed, address accepted |

## Verification
Two functions can fall on the same edge: the registration of an attempt's result (the checksum verdict and `done`) and the sampling of a new `start` request. The bench provokes this by holding `start` high through a failing attempt. It expects the request to be dropped on the result edge and accepted on the next edge, which gives exactly two `done` pulses, sixteen reads and correct addresses in a 20-cycle window. A start pulse in the middle of an attempt checks the same rule during the read phase.

// File: rtl/station_id_pkg.sv
package station_id_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_DRAIN,
    SQ_LOCKED
  } seq_state_t;

endpackage

// File: rtl/sid_seq.sv
module sid_seq
  import station_id_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int ADDR_LSB  = 4,
  parameter int IDX_W     = $clog2(NUM_BYTES),
  parameter int AW        = IDX_W + ADDR_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fin_strobe,
  input  logic             fin_pass,
  output logic             clear,
  output logic             prom_rd,
  output logic [AW-1:0]    prom_addr,
  output logic             cap_vld,
  output logic             cap_last,
  output logic [IDX_W-1:0] cap_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] idx;

  assign clear     = (state == SQ_IDLE) && start;
  assign prom_rd   = (state == SQ_ISSUE);
  assign prom_addr = {idx, {ADDR_LSB{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      idx      <= '0;
      cap_vld  <= 1'b0;
      cap_last <= 1'b0;
      cap_idx  <= '0;
    end else begin
      cap_vld  <= prom_rd;
      cap_last <= prom_rd && (idx == LAST_IDX);
      cap_idx  <= idx;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            state <= SQ_ISSUE;
            idx   <= '0;
          end
        end
        SQ_ISSUE: begin
          if (idx == LAST_IDX) state <= SQ_DRAIN;
          else                 idx   <= idx + 1'b1;
        end
        SQ_DRAIN: begin
          if (fin_strobe) state <= fin_pass ? SQ_LOCKED : SQ_IDLE;
        end
        default: state <= SQ_LOCKED;
      endcase
    end
  end

  // Read budget counter used only by the checks below.
  logic [IDX_W:0] rd_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_seen <= '0;
    else if (clear)   rd_seen <= '0;
    else if (prom_rd) rd_seen <= rd_seen + 1'b1;
  end

  AST_READ_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_seen <= (IDX_W+1)'(NUM_BYTES)); // R1

  AST_SPARSE_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    prom_rd |-> (prom_addr[ADDR_LSB-1:0] == '0)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    prom_rd && $past(prom_rd) |->
      prom_addr == $past(prom_addr) + AW'(1 << ADDR_LSB)); // R1

endmodule

// File: rtl/sid_accum.sv
module sid_accum #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 3,
  parameter int MAC_W      = ADDR_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_vld,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [DATA_W-1:0] prom_data,
  output logic [MAC_W-1:0]  fin_mac,
  output logic [DATA_W-1:0] fin_chk
);

  localparam logic [IDX_W:0] KEEP_N = (IDX_W+1)'(ADDR_BYTES);

  logic [DATA_W-1:0] flipped;
  logic [DATA_W-1:0] chk_acc;
  logic [MAC_W-1:0]  mac_sh;

  for (genvar g = 0; g < DATA_W; g++) begin : g_flip
    assign flipped[g] = prom_data[DATA_W-1-g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_acc <= '0;
      mac_sh  <= '0;
    end else if (clear) begin
      chk_acc <= '0;
      mac_sh  <= '0;
    end else if (cap_vld) begin
      chk_acc <= chk_acc ^ flipped;
      if ({1'b0, cap_idx} < KEEP_N)
        mac_sh <= {mac_sh[MAC_W-DATA_W-1:0], flipped};
    end
  end

  assign fin_mac = mac_sh;
  assign fin_chk = chk_acc ^ flipped;

endmodule

// File: rtl/sid_result.sv
module sid_result #(
  parameter int DATA_W      = 8,
  parameter int MAC_W       = 48,
  parameter int CHECK_VALUE = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fin_strobe,
  input  logic [MAC_W-1:0]  fin_mac,
  input  logic [DATA_W-1:0] fin_chk,
  output logic              fin_pass,
  output logic [MAC_W-1:0]  mac_addr,
  output logic              done,
  output logic              id_valid
);

  localparam logic [DATA_W-1:0] GOOD_SUM = DATA_W'(CHECK_VALUE);

  assign fin_pass = (fin_chk == GOOD_SUM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      id_valid <= 1'b0;
      mac_addr <= '0;
    end else begin
      done <= fin_strobe;
      if (clear) begin
        id_valid <= 1'b0;
        mac_addr <= '0;
      end else if (fin_strobe) begin
        id_valid <= fin_pass;
        mac_addr <= fin_pass ? fin_mac : '0;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> (mac_addr == '0)); // R6

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> id_valid && $stable(mac_addr)); // R8

endmodule

// File: rtl/station_id_loader.sv
module station_id_loader #(
  parameter int NUM_BYTES   = 8,
  parameter int ADDR_BYTES  = 6,
  parameter int DATA_W      = 8,
  parameter int STRIDE_LOG2 = 4,
  parameter int CHECK_VALUE = 255
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start,
  output logic                                    prom_rd,
  output logic [$clog2(NUM_BYTES)+STRIDE_LOG2-1:0] prom_addr,
  input  logic [DATA_W-1:0]                       prom_data,
  output logic [ADDR_BYTES*DATA_W-1:0]            mac_addr,
  output logic                                    done,
  output logic                                    id_valid
);

  localparam int IDX_W = $clog2(NUM_BYTES);
  localparam int AW    = IDX_W + STRIDE_LOG2;
  localparam int MAC_W = ADDR_BYTES * DATA_W;

  logic              clear;
  logic              cap_vld;
  logic              cap_last;
  logic [IDX_W-1:0]  cap_idx;
  logic [MAC_W-1:0]  fin_mac;
  logic [DATA_W-1:0] fin_chk;
  logic              fin_pass;
  logic              fin_strobe;

  assign fin_strobe = cap_vld && cap_last;

  sid_seq #(
    .NUM_BYTES (NUM_BYTES),
    .ADDR_LSB  (STRIDE_LOG2),
    .IDX_W     (IDX_W),
    .AW        (AW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fin_strobe (fin_strobe),
    .fin_pass   (fin_pass),
    .clear      (clear),
    .prom_rd    (prom_rd),
    .prom_addr  (prom_addr),
    .cap_vld    (cap_vld),
    .cap_last   (cap_last),
    .cap_idx    (cap_idx)
  );

  sid_accum #(
    .DATA_W     (DATA_W),
    .ADDR_BYTES (ADDR_BYTES),
    .IDX_W      (IDX_W),
    .MAC_W      (MAC_W)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .cap_vld   (cap_vld),
    .cap_idx   (cap_idx),
    .prom_data (prom_data),
    .fin_mac   (fin_mac),
    .fin_chk   (fin_chk)
  );

  sid_result #(
    .DATA_W      (DATA_W),
    .MAC_W       (MAC_W),
    .CHECK_VALUE (CHECK_VALUE)
  ) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .fin_strobe (fin_strobe),
    .fin_mac    (fin_mac),
    .fin_chk    (fin_chk),
    .fin_pass   (fin_pass),
    .mac_addr   (mac_addr),
    .done       (done),
    .id_valid   (id_valid)
  );

  AST_RESULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fin_strobe) |-> $stable(id_valid) || $fell(id_valid)); // R7

endmodule

// File: tb/station_id_loader_tb.sv
module station_id_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        prom_rd;
  logic [6:0]  prom_addr;
  logic [7:0]  prom_data = 8'h00;
  logic [47:0] mac_addr;
  logic        done;
  logic        id_valid;

  logic [7:0]  mem [128];
  int          n_checks = 0;
  int          n_fails  = 0;

  always #2 clk = ~clk;

  station_id_loader u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .prom_rd   (prom_rd),
    .prom_addr (prom_addr),
    .prom_data (prom_data),
    .mac_addr  (mac_addr),
    .done      (done),
    .id_valid  (id_valid)
  );

  // PROM model with a fixed read latency of one cycle.
  always @(posedge clk) if (prom_rd) prom_data <= mem[prom_addr];

  // Each entry: {mac[47:0], tail0[7:0], pass_flag[7:0]}
  localparam logic [63:0] VEC [6] = '{
    {48'h0800_2b4c_19e7, 8'h00, 8'h01},
    {48'hffff_ffff_ffff, 8'h5a, 8'h01},
    {48'h0000_0000_0000, 8'h00, 8'h01},
    {48'h1234_5678_9abc, 8'h3c, 8'h00},
    {48'h0a1b_2c3d_4e5f, 8'h81, 8'h01},
    {48'h0000_0000_0001, 8'hfe, 8'h00}
  };

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] xor_mac(input logic [47:0] m);
    logic [7:0] x = 8'h00;
    for (int i = 0; i < 6; i++) x ^= m[8*i +: 8];
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  // Store the six address bytes and two tail bytes bit-reversed on the 16-byte stride.
  task automatic load_prom(input logic [47:0] m, input logic [7:0] t0, input logic [7:0] t1);
    for (int a = 0; a < 128; a++) mem[a] = 8'hA5 ^ 8'(a);
    for (int k = 0; k < 6; k++) mem[k*16] = rev8(m[47-8*k -: 8]);
    mem[96]  = rev8(t0);
    mem[112] = rev8(t1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  // Run a 20-cycle window after a start edge. k counts edges from the start edge (k=0).
  task automatic run(input int poke_k, input bit hold,
                     output int done_at, output int ndone, output int nreads, output int addr_err);
    done_at = -1; ndone = 0; nreads = 0; addr_err = 0;
    @(negedge clk) start = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      #1;
      start = hold || (k + 1 == poke_k);
      if (prom_rd) begin
        nreads++;
        if ((k % 10) > 7 || prom_addr != 7'((k % 10) * 16)) addr_err++;
      end
      if (done) begin
        ndone++;
        done_at = k;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int da, nd, nr, ae;
    logic [47:0] m;
    logic [7:0]  t0, t1;
    bit          pass;
    logic [47:0] held;

    load_prom(48'h0, 8'h00, 8'hff);
    rst_n = 1'b0;
    #1;
    chk(!prom_rd && !done && !id_valid && mac_addr == 48'h0, "R11 in reset",
        {prom_rd, done, id_valid}, 0);
    do_reset();
    #1;
    chk(!prom_rd && !done && !id_valid && mac_addr == 48'h0, "R11 after reset",
        {prom_rd, done, id_valid}, 0);

    // Table walk: one fresh reset per vector.
    for (int v = 0; v < 6; v++) begin
      m    = VEC[v][63:16];
      t0   = VEC[v][15:8];
      pass = VEC[v][0];
      t1   = 8'hff ^ xor_mac(m) ^ t0 ^ (pass ? 8'h00 : 8'h01);
      load_prom(m, t0, t1);
      do_reset();
      run(-1, 1'b0, da, nd, nr, ae);
      chk(nr == 8 && ae == 0, $sformatf("R1 reads v%0d", v), {nr, ae}, 8);
      chk(nd == 1 && da == 9, $sformatf("R7 done timing v%0d", v), {nd, da}, {32'd1, 32'd9});
      chk(id_valid == pass, $sformatf("R5 valid v%0d", v), id_valid, pass);
      chk(mac_addr == (pass ? m : 48'h0), $sformatf("R2 R3 R4 R6 addr v%0d", v),
          mac_addr, pass ? m : 48'h0);
    end

    // R8: a start after a pass does nothing.
    load_prom(48'h0a1b_2c3d_4e5f, 8'h81, 8'hff ^ xor_mac(48'h0a1b_2c3d_4e5f) ^ 8'h81);
    do_reset();
    run(-1, 1'b0, da, nd, nr, ae);
    held = mac_addr;
    load_prom(48'h1111_1111_1111, 8'h00, 8'hff);
    run(-1, 1'b0, da, nd, nr, ae);
    chk(nr == 0 && nd == 0, "R8 locked start ignored", {nr, nd}, 0);
    chk(id_valid && mac_addr == held, "R8 locked hold", mac_addr, held);

    // R9: start pulse mid-run is ignored.
    load_prom(48'h0800_2b4c_19e7, 8'h00, 8'hff ^ xor_mac(48'h0800_2b4c_19e7));
    do_reset();
    run(3, 1'b0, da, nd, nr, ae);
    chk(nr == 8 && nd == 1 && da == 9 && ae == 0, "R9 mid-run start", {nr, nd, da}, {32'd8, 32'd1, 32'd9});
    chk(id_valid && mac_addr == 48'h0800_2b4c_19e7, "R9 result intact", mac_addr, 48'h0800_2b4c_19e7);

    // R9/R10: start held through a failing run: dropped on the result edge, taken on the next.
    load_prom(48'h1234_5678_9abc, 8'h00, 8'h00);
    do_reset();
    run(-1, 1'b1, da, nd, nr, ae);
    chk(nd == 2 && nr == 16 && ae == 0 && da == 19, "R9 R10 held start", {nd, nr, da}, {32'd2, 32'd16, 32'd19});
    chk(!id_valid && mac_addr == 48'h0, "R6 held fail", mac_addr, 0);

    // R10: retry after failure with good contents.
    load_prom(48'h0202_0303_0404, 8'h77, 8'hff ^ xor_mac(48'h0202_0303_0404) ^ 8'h77);
    run(-1, 1'b0, da, nd, nr, ae);
    chk(nr == 8 && nd == 1 && da == 9, "R10 retry timing", {nr, nd, da}, {32'd8, 32'd1, 32'd9});
    chk(id_valid && mac_addr == 48'h0202_0303_0404, "R10 retry result", mac_addr, 48'h0202_0303_0404);

    // R4: tail bytes differ but checksum still passes, address unchanged.
    load_prom(48'h0202_0303_0404, 8'h10, 8'hff ^ xor_mac(48'h0202_0303_0404) ^ 8'h10);
    do_reset();
    run(-1, 1'b0, da, nd, nr, ae);
    chk(id_valid && mac_addr == 48'h0202_0303_0404, "R4 tail independence", mac_addr, 48'h0202_0303_0404);

    // R11: reset clears a locked result.
    do_reset();
    #1;
    chk(!id_valid && mac_addr == 48'h0 && !done, "R11 reset clears", mac_addr, 0);

    summary();
  end

endmodule